// File: doc/BRIEF.md
# Sync-Tip Level and Gain Servo Controller

This block is the digital half of two servo loops in a composite-video front end. It watches 10-bit converter samples and uses two timing strobes from a sync processor. One strobe marks the sync-tip interval and the other marks the blanking interval. It averages each level over a fixed window of strobed samples. From those averages it drives two outputs. The first is a direction-and-weight command for a current DAC that pushes the AC-coupled input up or down, so that the sync tip settles at code 32. The second is a 4-bit code for a variable-gain amplifier, so that the distance from tip to blanking settles at 208 codes.

A small configuration port sets the correction speed, switches the automatic gain loop on or off, and holds a manual gain code. The manual code drives the amplifier while the loop is off. The gain code moves by at most one step per video line, and only at the line marker. The current-DAC command is re-decided each time a new tip average completes and is held between averages.

Top module: `sync_level_gain_loop`

## Requirements
- R1: After reset, the gain code is 0, the restore direction is idle (encoding 0), the restore weight is 0, the speed setting is 2 (medium-fast), the gain loop is enabled and the manual gain is 0.
- R2: A level average is the floor of the mean of exactly 2^AVG_LOG2 samples (4 by default) taken while the matching strobe is high. Samples presented while the strobe is low have no effect on it.
- R3: When a tip average completes, the restore direction becomes source (encoding 1) if the average is below 30. It becomes sink (encoding 2) if the average is above 34. Otherwise it becomes idle (encoding 0).
- R4: The restore weight is 3, 6, 12 or 24 for speed codes 0, 1, 2 and 3, and is 0 whenever the direction is idle.
- R5: At a line marker, if a new blanking average has completed since the previous marker and a tip average exists, the amplitude is taken as blanking average minus tip average. With the gain loop on, an amplitude below 206 raises the gain code by 1, above 210 lowers it by 1, and 206 to 210 leaves it unchanged.
- R6: The gain code changes in automatic mode only in the clock edge that samples a line marker. A marker with no new blanking average since the previous marker leaves it unchanged.
- R7: The automatic gain code saturates at 15 and at 0 and never wraps.
- R8: With the gain loop off, the gain code equals the manual gain register one edge after that register is written, and line markers do not move it. When the loop is turned back on, stepping resumes from that value.
- R9: The restore direction is held between completed tip averages, whatever the blanking samples and line markers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 10 | Converter sample |
| tip_stb_i | input | 1 | Sample lies inside the sync tip |
| blank_stb_i | input | 1 | Sample lies on the blanking level |
| line_start_i | input | 1 | One-cycle marker at each video line |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_speed_i | input | 2 | Speed code 0 to 3 (slow to fast) |
| cfg_agc_en_i | input | 1 | 1 enables the automatic gain loop |
| cfg_manual_gain_i | input | 4 | Gain code used while the loop is off |
| restore_dir_o | output | 2 | 0 idle, 1 source, 2 sink |
| restore_mag_o | output | 5 | Restore current weight |
| gain_code_o | output | 4 | Amplifier gain code |

## Verification
A tip or blanking average is registered on the edge that takes its last strobed sample. The restore direction follows on the next edge, so the bench checks it one cycle after the fourth tip sample. A blanking average becomes pending one edge after it completes, and the gain responds on the edge that samples the line marker. The bench therefore waits two cycles before raising the marker and checks the code at the falling edge that follows. Configuration writes reach the restore weight after one edge and the manual gain after two, and each check is placed at the falling edge after the last of those edges.

// File: rtl/slg_pkg.sv
package slg_pkg;

    localparam int SAMPLE_W    = 10;
    localparam int GAIN_W      = 4;
    localparam int MAG_W       = 5;
    localparam int TIP_TARGET  = 32;
    localparam int SPAN_TARGET = 208;
    localparam int DEADBAND    = 2;
    localparam int GAIN_MAX    = (1 << GAIN_W) - 1;
    localparam int BASE_WEIGHT = 3;

    typedef enum logic [1:0] {
        RST_IDLE   = 2'd0,
        RST_SOURCE = 2'd1,
        RST_SINK   = 2'd2
    } restore_dir_e;

    typedef enum logic [1:0] {
        SPD_SLOW    = 2'd0,
        SPD_MED     = 2'd1,
        SPD_MEDFAST = 2'd2,
        SPD_FAST    = 2'd3
    } speed_e;

    typedef struct packed {
        speed_e              speed;
        logic                agc_en;
        logic [GAIN_W-1:0]   manual_gain;
    } loop_cfg_t;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] level;
    } level_avg_t;

    function automatic logic [MAG_W-1:0] step_weight(speed_e s);
        return MAG_W'(BASE_WEIGHT << s);
    endfunction

    function automatic restore_dir_e restore_decision(logic [SAMPLE_W-1:0] lvl);
        int v;
        v = int'(lvl);
        if (v < TIP_TARGET - DEADBAND)      return RST_SOURCE;
        else if (v > TIP_TARGET + DEADBAND) return RST_SINK;
        else                                return RST_IDLE;
    endfunction

    // +1 raise gain, -1 lower gain, 0 hold
    function automatic int gain_direction(logic [SAMPLE_W-1:0] blank_lvl,
                                          logic [SAMPLE_W-1:0] tip_lvl);
        int amp;
        amp = int'(blank_lvl) - int'(tip_lvl);
        if (amp < SPAN_TARGET - DEADBAND)      return 1;
        else if (amp > SPAN_TARGET + DEADBAND) return -1;
        else                                   return 0;
    endfunction

endpackage

// File: rtl/slg_cfg_regs.sv
module slg_cfg_regs
    import slg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  loop_cfg_t         wdata_i,
    output loop_cfg_t         cfg_o
);

    loop_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.speed       <= SPD_MEDFAST;
            cfg_q.agc_en      <= 1'b1;
            cfg_q.manual_gain <= '0;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(we_i) |-> cfg_q == $past(cfg_q)) else $error("cfg changed without write"); // R8

endmodule

// File: rtl/slg_level_avg.sv
module slg_level_avg
    import slg_pkg::*;
#(
    parameter int AVG_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output level_avg_t          avg_o
);

    localparam int ACC_W = SAMPLE_W + AVG_LOG2;
    localparam logic [AVG_LOG2-1:0] LAST_IDX = {AVG_LOG2{1'b1}};

    logic [ACC_W-1:0]    acc_q;
    logic [AVG_LOG2-1:0] cnt_q;
    logic [ACC_W-1:0]    sum_w;
    level_avg_t          avg_q;

    assign sum_w = acc_q + ACC_W'(sample_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            cnt_q       <= '0;
            avg_q.valid <= 1'b0;
            avg_q.level <= '0;
        end else begin
            avg_q.valid <= 1'b0;
            if (strobe_i) begin
                if (cnt_q == LAST_IDX) begin
                    avg_q.level <= sum_w[ACC_W-1:AVG_LOG2];
                    avg_q.valid <= 1'b1;
                    acc_q       <= '0;
                    cnt_q       <= '0;
                end else begin
                    acc_q <= sum_w;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign avg_o = avg_q;

    AST_AVG_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe_i) |-> cnt_q == $past(cnt_q)) else $error("count moved without strobe"); // R2
    AST_AVG_IDLE_VALID: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe_i) |-> !avg_q.valid) else $error("average without strobe"); // R2

endmodule

// File: rtl/slg_restore_ctrl.sv
module slg_restore_ctrl
    import slg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  level_avg_t        tip_i,
    input  speed_e            speed_i,
    output restore_dir_e      dir_o,
    output logic [MAG_W-1:0]  mag_o
);

    restore_dir_e dir_q;

    always_ff @(posedge clk) begin
        if (rst)              dir_q <= RST_IDLE;
        else if (tip_i.valid) dir_q <= restore_decision(tip_i.level);
    end

    assign dir_o = dir_q;
    assign mag_o = (dir_q == RST_IDLE) ? '0 : step_weight(speed_i);

    AST_RESTORE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ($past(tip_i.valid) && int'($past(tip_i.level)) < TIP_TARGET - DEADBAND)
        |-> dir_q == RST_SOURCE) else $error("low tip not sourced"); // R3
    AST_RESTORE_SINK: assert property (@(posedge clk) disable iff (rst)
        ($past(tip_i.valid) && int'($past(tip_i.level)) > TIP_TARGET + DEADBAND)
        |-> dir_q == RST_SINK) else $error("high tip not sunk"); // R3
    AST_RESTORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(tip_i.valid) |-> dir_q == $past(dir_q)) else $error("restore moved between averages"); // R9

endmodule

// File: rtl/slg_gain_ctrl.sv
module slg_gain_ctrl
    import slg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  level_avg_t        tip_i,
    input  level_avg_t        blank_i,
    input  logic              line_start_i,
    input  loop_cfg_t         cfg_i,
    output logic [GAIN_W-1:0] gain_o
);

    localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);

    logic [GAIN_W-1:0] gain_q;
    logic              pending_q;
    logic              tip_seen_q;
    int                dir_w;

    assign dir_w = gain_direction(blank_i.level, tip_i.level);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q     <= '0;
            pending_q  <= 1'b0;
            tip_seen_q <= 1'b0;
        end else begin
            tip_seen_q <= tip_seen_q | tip_i.valid;
            pending_q  <= blank_i.valid | (pending_q & ~line_start_i);
            if (!cfg_i.agc_en) begin
                gain_q <= cfg_i.manual_gain;
            end else if (line_start_i && pending_q && tip_seen_q) begin
                if (dir_w > 0 && gain_q != GMAX)
                    gain_q <= gain_q + 1'b1;
                else if (dir_w < 0 && gain_q != '0)
                    gain_q <= gain_q - 1'b1;
            end
        end
    end

    assign gain_o = gain_q;

    AST_GAIN_LINE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_i.agc_en) && gain_q != $past(gain_q)) |-> $past(line_start_i))
        else $error("gain moved off line marker"); // R6
    AST_GAIN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_i.agc_en) |-> !(($past(gain_q) == GMAX && gain_q == '0) ||
                                  ($past(gain_q) == '0 && gain_q == GMAX)))
        else $error("gain wrapped"); // R7
    AST_GAIN_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_i.agc_en) |-> gain_q == $past(cfg_i.manual_gain))
        else $error("manual gain not applied"); // R8

endmodule

// File: rtl/sync_level_gain_loop.sv
module sync_level_gain_loop
    import slg_pkg::*;
#(
    parameter int AVG_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                tip_stb_i,
    input  logic                blank_stb_i,
    input  logic                line_start_i,
    input  logic                cfg_we_i,
    input  logic [1:0]          cfg_speed_i,
    input  logic                cfg_agc_en_i,
    input  logic [GAIN_W-1:0]   cfg_manual_gain_i,
    output logic [1:0]          restore_dir_o,
    output logic [MAG_W-1:0]    restore_mag_o,
    output logic [GAIN_W-1:0]   gain_code_o
);

    localparam int N_LEVELS = 2;
    localparam int IDX_TIP   = 0;
    localparam int IDX_BLANK = 1;

    loop_cfg_t    cfg_wdata;
    loop_cfg_t    cfg;
    logic         strobe [N_LEVELS];
    level_avg_t   avg    [N_LEVELS];
    restore_dir_e dir;

    assign cfg_wdata.speed       = speed_e'(cfg_speed_i);
    assign cfg_wdata.agc_en      = cfg_agc_en_i;
    assign cfg_wdata.manual_gain = cfg_manual_gain_i;

    assign strobe[IDX_TIP]   = tip_stb_i;
    assign strobe[IDX_BLANK] = blank_stb_i;

    slg_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    for (genvar c = 0; c < N_LEVELS; c++) begin : g_level
        slg_level_avg #(.AVG_LOG2(AVG_LOG2)) u_avg (
            .clk      (clk),
            .rst      (rst),
            .strobe_i (strobe[c]),
            .sample_i (sample_i),
            .avg_o    (avg[c])
        );
    end

    slg_restore_ctrl u_restore (
        .clk     (clk),
        .rst     (rst),
        .tip_i   (avg[IDX_TIP]),
        .speed_i (cfg.speed),
        .dir_o   (dir),
        .mag_o   (restore_mag_o)
    );

    slg_gain_ctrl u_gain (
        .clk          (clk),
        .rst          (rst),
        .tip_i        (avg[IDX_TIP]),
        .blank_i      (avg[IDX_BLANK]),
        .line_start_i (line_start_i),
        .cfg_i        (cfg),
        .gain_o       (gain_code_o)
    );

    assign restore_dir_o = dir;

endmodule

// File: tb/sync_level_gain_loop_bench.sv
module sync_level_gain_loop_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sample = '0;
    logic       tip_stb = 1'b0;
    logic       blank_stb = 1'b0;
    logic       line_start = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_speed = 2'd2;
    logic       cfg_agc_en = 1'b1;
    logic [3:0] cfg_manual = '0;
    logic [1:0] dir;
    logic [4:0] mag;
    logic [3:0] gain;

    int checks = 0;
    int failures = 0;
    int exp_gain = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sync_level_gain_loop u_sync_level_gain_loop (
        .clk               (clk),
        .rst               (rst),
        .sample_i          (sample),
        .tip_stb_i         (tip_stb),
        .blank_stb_i       (blank_stb),
        .line_start_i      (line_start),
        .cfg_we_i          (cfg_we),
        .cfg_speed_i       (cfg_speed),
        .cfg_agc_en_i      (cfg_agc_en),
        .cfg_manual_gain_i (cfg_manual),
        .restore_dir_o     (dir),
        .restore_mag_o     (mag),
        .gain_code_o       (gain)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // four strobed samples, optional garbage cycle (strobe low, 1023) between them
    task automatic push_level(input bit is_tip, input int a, input int b,
                              input int c, input int d, input bit gap);
        int v [4];
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int i = 0; i < 4; i++) begin
            sample = 10'(v[i]);
            tip_stb = is_tip; blank_stb = !is_tip;
            step(1);
            tip_stb = 1'b0; blank_stb = 1'b0;
            if (gap) begin
                sample = 10'd1023;
                step(1);
            end
        end
        sample = '0;
    endtask

    task automatic cfg_write(input int spd, input bit en, input int man);
        cfg_speed = 2'(spd); cfg_agc_en = en; cfg_manual = 4'(man); cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic line_pulse();
        line_start = 1'b1;
        step(1);
        line_start = 1'b0;
    endtask

    function automatic int exp_dir(input int lvl);
        if (lvl < 30) return 1;
        if (lvl > 34) return 2;
        return 0;
    endfunction

    // one line with a fresh blanking average at span amp over tip 32
    task automatic gain_line(input int amp, input string req);
        push_level(1'b0, 32 + amp, 32 + amp, 32 + amp, 32 + amp, 1'b0);
        step(2);
        line_pulse();
        if (amp < 206 && exp_gain < 15) exp_gain++;
        else if (amp > 210 && exp_gain > 0) exp_gain--;
        chk(req, gain, exp_gain);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 gain", gain, 0);
        chk("R1 dir", dir, 0);
        chk("R1 mag", mag, 0);

        // R3 sweep of constant tip levels, default speed weight 12 (R1, R4)
        for (int lvl = 20; lvl <= 44; lvl++) begin
            push_level(1'b1, lvl, lvl, lvl, lvl, 1'b0);
            step(1);
            chk("R3 dir", dir, exp_dir(lvl));
            chk("R4 mag", mag, exp_dir(lvl) == 0 ? 0 : 12);
        end

        // R2 averaging with floor and ignored gap samples
        push_level(1'b1, 28, 29, 29, 30, 1'b1);
        step(1);
        chk("R2 mean 29 with gaps", dir, 1);
        push_level(1'b1, 34, 35, 35, 35, 1'b1);
        step(1);
        chk("R2 floor 34", dir, 0);
        push_level(1'b1, 30, 30, 31, 29, 1'b0);
        step(1);
        chk("R2 floor 30", dir, 0);

        // R4 speed weights while sinking
        push_level(1'b1, 40, 40, 40, 40, 1'b0);
        step(1);
        for (int s = 0; s < 4; s++) begin
            cfg_write(s, 1'b1, 0);
            chk("R4 weight", mag, 3 << s);
        end
        // R9 hold between averages
        step(10);
        sample = 10'd0;
        chk("R9 hold", dir, 2);

        // tip at 32 for the gain loop
        push_level(1'b1, 32, 32, 32, 32, 1'b0);
        step(1);
        chk("R3 target", dir, 0);

        // R5/R7 climb to saturation at 15
        for (int i = 0; i < 17; i++) gain_line(100, "R5 R7 up");
        chk("R7 top", gain, 15);
        // R5 boundaries
        gain_line(206, "R5 206 hold");
        gain_line(210, "R5 210 hold");
        gain_line(211, "R5 211 down");
        gain_line(205, "R5 205 up");
        // R9 restore unaffected by blanking traffic
        chk("R9 blank traffic", dir, 0);
        // R6 marker without new average
        line_pulse();
        chk("R6 stale", gain, exp_gain);
        // R6 average without marker
        push_level(1'b0, 332, 332, 332, 332, 1'b0);
        step(4);
        chk("R6 no marker", gain, exp_gain);
        line_pulse();
        exp_gain--;
        chk("R6 marker", gain, exp_gain);
        // R7 descend to 0
        for (int i = 0; i < 17; i++) gain_line(300, "R5 R7 down");
        chk("R7 bottom", gain, 0);

        // R8 manual mode
        cfg_write(2, 1'b0, 9);
        step(1);
        chk("R8 manual", gain, 9);
        push_level(1'b0, 132, 132, 132, 132, 1'b0);
        step(2);
        line_pulse();
        chk("R8 ignore marker", gain, 9);
        cfg_write(2, 1'b0, 4);
        step(1);
        chk("R8 rewrite", gain, 4);
        cfg_write(2, 1'b1, 4);
        exp_gain = 4;
        gain_line(100, "R8 resume");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule